// File: doc/BRIEF.md
# Multi-Rail Display Power-Up Sequencer

This controller brings up the supply rails of a display panel in a fixed order of six timed phases. Each phase lasts a set number of clock cycles. A check is tied to particular phases: the reference is confirmed good late in phase 2, each rail's undervoltage flag begins to count once that rail has had its enabling phase, and the gate levels of the input-protection switch and the delayed-boost switch are confirmed when sequencing completes. Over-temperature counts as a fault in every active cycle. The analog side (ramps, regulation loops and comparators) lies outside the block, and each of its results arrives here as a one-bit flag.

When a fault is seen, the controller freezes its outputs and runs a fault timeout. When the timeout ends, it switches every rail off, releases the protection switch, and stays latched off. The latch clears only when the enable input or the input supply is cycled. A build-time variant keeps the reference and the logic rail powered whenever the input supply is valid, without waiting for the enable input. In that variant a latched fault turns the logic rail off but leaves the reference on.

A status port reports the current phase and whether the fault latch is set.

Top module: `rail_seq_ctrl`

## Requirements
- R1: Reset and idle state:
  - every rail enable, the soft-start flag and the delay-switch drive are 0;
  - `prot_drv_n_o` is 1;
  - `phase_o` is 0 and `fault_latched_o` is 0.
- R2: Start-up and phase timing:
  - In idle, with `en_i` and `supply_ok_i` both high, `phase_o` becomes 1 on the next clock.
  - Each of phases 1 to 6 lasts exactly PHASE_CYC cycles.
  - After phase 6, `phase_o` reads 7, which is normal operation.
  - While running, `phase_o` only ever steps up by one.
- R3: Output schedule by phase:
  - `ref_en_o` is on from phase 2.
  - From phase 3, `prot_drv_n_o` is 0 and `boost_en_o` is 1.
  - `neg_en_o` is on from phase 4, `dly_sw_o` from phase 5 and `pos_en_o` from phase 6.
  - All of these stay on in normal operation.
- R4: `ss_active_o` is 1 for exactly SS_CYC cycles, starting with the first cycle of phase 3. It is only ever 1 while `boost_en_o` is 1.
- R5: `ref_good_i` is sampled on the last cycle of phase 2. If it is low there, a fault starts.
- R6: `over_temp_i` high in any cycle of phases 1 to 7 starts a fault.
- R7: Rail and gate flags are ignored until they are armed:
  - `uv_boost_i` and `uv_logic_i` count from the last cycle of phase 3.
  - `uv_neg_i` counts from the last cycle of phase 4.
  - `uv_pos_i`, a low `prot_gate_low_i` and a low `dly_gate_low_i` count from the last cycle of phase 6.
  - Before its arming point, a flag has no effect on any output.
- R8: Fault timeout and latch-off:
  - After a fault, `phase_o` and every output hold their values for FAULT_CYC cycles.
  - After that, `fault_latched_o` is 1, `phase_o` is 0, all rail enables are 0 and `prot_drv_n_o` is 1.
- R9: Once latched, the block stays latched for as long as `en_i` and `supply_ok_i` stay high. Dropping `en_i` clears the latch. Raising `en_i` again restarts the sequence at phase 1.
- R10: `en_i` low in any state returns the block to idle, with the R1 outputs, on the next clock.
- R11: `supply_ok_i` low in any state returns the block to idle on the next clock, which also clears the latch. No sequence starts while `supply_ok_i` is low.
- R12: With LOGIC_EARLY=1:
  - `ref_en_o` equals `supply_ok_i` in the same cycle.
  - `logic_en_o` equals `supply_ok_i` in the same cycle, except that it is 0 while latched.
  - The rest of the behaviour is the same as with LOGIC_EARLY=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Sequence enable |
| supply_ok_i | input | 1 | Input supply above its undervoltage level |
| ref_good_i | input | 1 | Reference is in regulation |
| over_temp_i | input | 1 | Over-temperature flag |
| uv_boost_i | input | 1 | Boost rail undervoltage |
| uv_logic_i | input | 1 | Logic rail undervoltage |
| uv_neg_i | input | 1 | Negative gate rail undervoltage |
| uv_pos_i | input | 1 | Positive gate rail undervoltage |
| prot_gate_low_i | input | 1 | Protection switch gate has been pulled low |
| dly_gate_low_i | input | 1 | Delayed-boost switch gate has been pulled low |
| ref_en_o | output | 1 | Reference enable |
| prot_drv_n_o | output | 1 | Protection switch drive, active low |
| boost_en_o | output | 1 | Boost rail enable |
| ss_active_o | output | 1 | Boost soft-start window in progress |
| logic_en_o | output | 1 | Logic rail enable |
| neg_en_o | output | 1 | Negative gate rail enable |
| dly_sw_o | output | 1 | Delayed-boost switch drive |
| pos_en_o | output | 1 | Positive gate rail enable |
| phase_o | output | 3 | 0 idle or latched, 1 to 6 sequencing, 7 running |
| fault_latched_o | output | 1 | Fault latch is set |

## Verification
Every registered result appears one clock after the input sample that causes it:
- the phase step;
- the entry into the timeout;
- the return to idle.

The latch sets FAULT_CYC clocks after the timeout begins. Each phase-end check looks at its flags on the cycle before the phase number changes. In the early variant, the reference and logic enables follow `supply_ok_i` in the same cycle with no register in between.

The bench drives its inputs shortly after the rising edge. It advances a behavioural model on the same rising edge, then compares every output of both variants with the model on the falling edge. Scenario checks are placed on clock counts measured from the edge at which the stimulus is first sampled.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEQ   = 3'd1,
    ST_RUN   = 3'd2,
    ST_TMO   = 3'd3,
    ST_LATCH = 3'd4
  } seq_st_e;

  localparam int unsigned PH_W     = 3;
  localparam int unsigned NUM_PH   = 6;
  localparam int unsigned NUM_RAIL = 4;   // 0 boost, 1 logic, 2 negative, 3 positive

  localparam logic [PH_W-1:0] PH_IDLE  = 3'd0;
  localparam logic [PH_W-1:0] PH_FIRST = 3'd1;
  localparam logic [PH_W-1:0] PH_LAST  = 3'(NUM_PH);
  localparam logic [PH_W-1:0] PH_RUN   = 3'd7;

  // phase in which each rail is switched on; its undervoltage flag is armed
  // from the last cycle of that phase
  function automatic logic [PH_W-1:0] rail_on_phase(input int unsigned idx);
    case (idx)
      0:       return 3'd3;
      1:       return 3'd3;
      2:       return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rseq_fault_eval.sv
module rseq_fault_eval
  import rseq_pkg::*;
(
  input  logic                in_seq_i,
  input  logic                in_run_i,
  input  logic [PH_W-1:0]     phase_i,
  input  logic                phase_end_i,
  input  logic                over_temp_i,
  input  logic                ref_good_i,
  input  logic [NUM_RAIL-1:0] uv_i,
  input  logic                prot_gate_low_i,
  input  logic                dly_gate_low_i,
  output logic                fault_o
);

  logic [NUM_RAIL-1:0] uv_hit;
  logic                ref_bad, gate_bad, any_uv;

  for (genvar g = 0; g < NUM_RAIL; g++) begin : g_rail
    localparam logic [PH_W-1:0] ON_PH = rail_on_phase(g);
    logic armed;
    assign armed     = in_run_i |
                       (in_seq_i & ((phase_i > ON_PH) | ((phase_i == ON_PH) & phase_end_i)));
    assign uv_hit[g] = armed & uv_i[g];
  end

  always_comb begin
    any_uv   = |uv_hit;
    ref_bad  = in_seq_i & (phase_i == 3'd2) & phase_end_i & ~ref_good_i;
    gate_bad = (in_run_i | (in_seq_i & (phase_i == PH_LAST) & phase_end_i)) &
               (~prot_gate_low_i | ~dly_gate_low_i);
    fault_o  = (in_seq_i | in_run_i) & (over_temp_i | ref_bad | any_uv | gate_bad);
  end

endmodule

// File: rtl/rseq_softstart.sv
module rseq_softstart #(
  parameter int unsigned SS_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  output logic active_o
);

  localparam int unsigned SS_W = $clog2(SS_CYC + 1);

  logic [SS_W-1:0] left_q, left_d;
  logic            left_en;

  always_comb begin
    left_en = clear_i | load_i | (left_q != '0);
    if (clear_i)     left_d = '0;
    else if (load_i) left_d = SS_W'(SS_CYC);
    else             left_d = left_q - SS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign active_o = (left_q != '0);

endmodule

// File: rtl/rseq_out_decode.sv
module rseq_out_decode
  import rseq_pkg::*;
(
  input  seq_st_e         st_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            ref_on_o,
  output logic            prot_drv_n_o,
  output logic            boost_on_o,
  output logic            logic_on_o,
  output logic            neg_on_o,
  output logic            dly_on_o,
  output logic            pos_on_o
);

  logic live;

  always_comb begin
    live         = (st_i == ST_SEQ) | (st_i == ST_RUN) | (st_i == ST_TMO);
    ref_on_o     = live & (phase_i >= 3'd2);
    boost_on_o   = live & (phase_i >= 3'd3);
    logic_on_o   = live & (phase_i >= 3'd3);
    prot_drv_n_o = ~(live & (phase_i >= 3'd3));
    neg_on_o     = live & (phase_i >= 3'd4);
    dly_on_o     = live & (phase_i >= 3'd5);
    pos_on_o     = live & (phase_i >= 3'd6);
  end

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rseq_pkg::*;
#(
  parameter int unsigned PHASE_CYC   = 100000,
  parameter int unsigned FAULT_CYC   = 500000,
  parameter int unsigned SS_CYC      = 20000,
  parameter bit          LOGIC_EARLY = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            supply_ok_i,
  input  logic            ref_good_i,
  input  logic            over_temp_i,
  input  logic            uv_boost_i,
  input  logic            uv_logic_i,
  input  logic            uv_neg_i,
  input  logic            uv_pos_i,
  input  logic            prot_gate_low_i,
  input  logic            dly_gate_low_i,
  output logic            ref_en_o,
  output logic            prot_drv_n_o,
  output logic            boost_en_o,
  output logic            ss_active_o,
  output logic            logic_en_o,
  output logic            neg_en_o,
  output logic            dly_sw_o,
  output logic            pos_en_o,
  output logic [PH_W-1:0] phase_o,
  output logic            fault_latched_o
);

  localparam int unsigned CNT_MAX = (PHASE_CYC > FAULT_CYC) ? PHASE_CYC : FAULT_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PH_TC  = CNT_W'(PHASE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_TC = CNT_W'(FAULT_CYC - 1);

  // reset synchroniser: asserted at once, released on the second edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  seq_st_e          st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;
  logic             abort, phase_end, tmo_end, fault;
  logic             ss_load, ss_clear;

  rseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  assign phase_end = (cnt == PH_TC);
  assign tmo_end   = (cnt == TMO_TC);

  rseq_fault_eval u_fault (
    .in_seq_i        (st_q == ST_SEQ),
    .in_run_i        (st_q == ST_RUN),
    .phase_i         (ph_q),
    .phase_end_i     (phase_end),
    .over_temp_i     (over_temp_i),
    .ref_good_i      (ref_good_i),
    .uv_i            ({uv_pos_i, uv_neg_i, uv_logic_i, uv_boost_i}),
    .prot_gate_low_i (prot_gate_low_i),
    .dly_gate_low_i  (dly_gate_low_i),
    .fault_o         (fault)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    ss_load = 1'b0;
    abort   = ~en_i | ~supply_ok_i;
    unique case (st_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (!abort) begin
          st_d = ST_SEQ;
          ph_d = PH_FIRST;
        end
      end
      ST_SEQ: begin
        if (abort) begin
          st_d    = ST_IDLE;
          ph_d    = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (fault) begin
          st_d    = ST_TMO;
          cnt_clr = 1'b1;
        end else if (phase_end) begin
          cnt_clr = 1'b1;
          if (ph_q == PH_LAST) begin
            st_d = ST_RUN;
            ph_d = PH_RUN;
          end else begin
            ph_d    = ph_q + 3'd1;
            ss_load = (ph_q == 3'd2);
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_clr = 1'b1;
        if (abort) begin
          st_d = ST_IDLE;
          ph_d = PH_IDLE;
        end else if (fault) begin
          st_d = ST_TMO;
        end
      end
      ST_TMO: begin
        if (abort) begin
          st_d    = ST_IDLE;
          ph_d    = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (tmo_end) begin
          st_d    = ST_LATCH;
          ph_d    = PH_IDLE;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_LATCH: begin
        cnt_clr = 1'b1;
        if (abort) st_d = ST_IDLE;
      end
      default: begin
        st_d    = ST_IDLE;
        ph_d    = PH_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
    ss_clear = (st_d == ST_IDLE) | (st_d == ST_LATCH);
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q <= ST_IDLE;
      ph_q <= PH_IDLE;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  rseq_softstart #(.SS_CYC(SS_CYC)) u_ss (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .load_i   (ss_load),
    .clear_i  (ss_clear),
    .active_o (ss_active_o)
  );

  logic ref_seq, logic_seq;

  rseq_out_decode u_dec (
    .st_i         (st_q),
    .phase_i      (ph_q),
    .ref_on_o     (ref_seq),
    .prot_drv_n_o (prot_drv_n_o),
    .boost_on_o   (boost_en_o),
    .logic_on_o   (logic_seq),
    .neg_on_o     (neg_en_o),
    .dly_on_o     (dly_sw_o),
    .pos_on_o     (pos_en_o)
  );

  if (LOGIC_EARLY) begin : g_early
    assign ref_en_o   = supply_ok_i;
    assign logic_en_o = supply_ok_i & (st_q != ST_LATCH);
    logic unused_seq;
    assign unused_seq = ref_seq ^ logic_seq;
  end else begin : g_seq
    assign ref_en_o   = ref_seq;
    assign logic_en_o = logic_seq;
  end

  assign phase_o         = ph_q;
  assign fault_latched_o = (st_q == ST_LATCH);

endmodule

// File: rtl/rseq_chk.sv
module rseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       supply_ok_i,
  input logic       prot_drv_n_o,
  input logic       boost_en_o,
  input logic       ss_active_o,
  input logic       neg_en_o,
  input logic       dly_sw_o,
  input logic       pos_en_o,
  input logic [2:0] phase_o,
  input logic       fault_latched_o
);

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_o) != 3'd0 && phase_o != 3'd0 && phase_o != $past(phase_o))
      |-> phase_o == 3'($past(phase_o) + 3'd1));

  p_pos_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_en_o |-> (neg_en_o && dly_sw_o));

  p_neg_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_en_o |-> (boost_en_o && !prot_drv_n_o));

  p_ss_in_boost_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_active_o |-> boost_en_o);

  p_latched_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_latched_o |-> (!boost_en_o && !neg_en_o && !pos_en_o && !dly_sw_o &&
                         prot_drv_n_o && phase_o == 3'd0));

  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_latched_o && en_i && supply_ok_i) |=> fault_latched_o);

  p_en_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_o == 3'd0 && !fault_latched_o && !boost_en_o && prot_drv_n_o));

  p_supply_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (phase_o == 3'd0 && !fault_latched_o && !neg_en_o));

endmodule

bind rail_seq_ctrl rseq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .supply_ok_i     (supply_ok_i),
  .prot_drv_n_o    (prot_drv_n_o),
  .boost_en_o      (boost_en_o),
  .ss_active_o     (ss_active_o),
  .neg_en_o        (neg_en_o),
  .dly_sw_o        (dly_sw_o),
  .pos_en_o        (pos_en_o),
  .phase_o         (phase_o),
  .fault_latched_o (fault_latched_o)
);

// File: tb/rail_seq_ctrl_tb_top.sv
module rail_seq_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int PC    = 6;
  localparam int FC    = 9;
  localparam int SS    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic en, sup, rg, ot, uvb, uvl, uvn, uvp, pgl, dlb;

  logic a_ref, a_prot, a_boost, a_ss, a_logic, a_neg, a_dly, a_pos, a_lat;
  logic [2:0] a_ph;
  logic b_ref, b_prot, b_boost, b_ss, b_logic, b_neg, b_dly, b_pos, b_lat;
  logic [2:0] b_ph;

  int vecs = 0;
  int errs = 0;
  bit cmp_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rail_seq_ctrl #(.PHASE_CYC(PC), .FAULT_CYC(FC), .SS_CYC(SS), .LOGIC_EARLY(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .supply_ok_i(sup), .ref_good_i(rg),
    .over_temp_i(ot), .uv_boost_i(uvb), .uv_logic_i(uvl), .uv_neg_i(uvn), .uv_pos_i(uvp),
    .prot_gate_low_i(pgl), .dly_gate_low_i(dlb),
    .ref_en_o(a_ref), .prot_drv_n_o(a_prot), .boost_en_o(a_boost), .ss_active_o(a_ss),
    .logic_en_o(a_logic), .neg_en_o(a_neg), .dly_sw_o(a_dly), .pos_en_o(a_pos),
    .phase_o(a_ph), .fault_latched_o(a_lat));

  rail_seq_ctrl #(.PHASE_CYC(PC), .FAULT_CYC(FC), .SS_CYC(SS), .LOGIC_EARLY(1'b1)) dut_e_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .supply_ok_i(sup), .ref_good_i(rg),
    .over_temp_i(ot), .uv_boost_i(uvb), .uv_logic_i(uvl), .uv_neg_i(uvn), .uv_pos_i(uvp),
    .prot_gate_low_i(pgl), .dly_gate_low_i(dlb),
    .ref_en_o(b_ref), .prot_drv_n_o(b_prot), .boost_en_o(b_boost), .ss_active_o(b_ss),
    .logic_en_o(b_logic), .neg_en_o(b_neg), .dly_sw_o(b_dly), .pos_en_o(b_pos),
    .phase_o(b_ph), .fault_latched_o(b_lat));

  // behavioural reference: 0 idle, 1 sequencing, 2 running, 3 timeout, 4 latched
  int ms, mp, mc, mss, rcnt;

  always @(posedge clk or negedge rst_n) begin : mdl
    int ns, np, nc, nss;
    bit ab, last, flt;
    if (!rst_n) begin
      ms = 0; mp = 0; mc = 0; mss = 0; rcnt = 0;
    end else if (rcnt < 2) begin
      rcnt = rcnt + 1;
    end else begin
      ab   = !en || !sup;
      last = (mc == PC - 1);
      flt  = 1'b0;
      if (ms == 1 || ms == 2) begin
        flt = ot;
        if (ms == 1 && mp == 2 && last && !rg) flt = 1'b1;
        if ((ms == 2 || (ms == 1 && (mp > 3 || (mp == 3 && last)))) && (uvb || uvl)) flt = 1'b1;
        if ((ms == 2 || (ms == 1 && (mp > 4 || (mp == 4 && last)))) && uvn) flt = 1'b1;
        if ((ms == 2 || (ms == 1 && mp == 6 && last)) && (uvp || !pgl || !dlb)) flt = 1'b1;
      end
      ns = ms; np = mp; nc = 0;
      nss = (mss > 0) ? mss - 1 : 0;
      case (ms)
        0: if (!ab) begin ns = 1; np = 1; end
        1: if (ab) begin ns = 0; np = 0; end
           else if (flt) ns = 3;
           else if (last) begin
             if (mp == 6) begin ns = 2; np = 7; end
             else begin np = mp + 1; if (mp == 2) nss = SS; end
           end else nc = mc + 1;
        2: if (ab) begin ns = 0; np = 0; end
           else if (flt) ns = 3;
        3: if (ab) begin ns = 0; np = 0; end
           else if (mc == FC - 1) begin ns = 4; np = 0; end
           else nc = mc + 1;
        default: if (ab) ns = 0;
      endcase
      if (ns == 0 || ns == 4) nss = 0;
      ms = ns; mp = np; mc = nc; mss = nss;
    end
  end

  function automatic bit on_at(int k);
    return (ms >= 1 && ms <= 3) && (mp >= k);
  endfunction

  task automatic cmp(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      cmp("R3 ref_en",        a_ref,   on_at(2));
      cmp("R3 prot_drv_n",    a_prot,  !on_at(3));
      cmp("R3 boost_en",      a_boost, on_at(3));
      cmp("R3 logic_en",      a_logic, on_at(3));
      cmp("R3 neg_en",        a_neg,   on_at(4));
      cmp("R3 dly_sw",        a_dly,   on_at(5));
      cmp("R3 pos_en",        a_pos,   on_at(6));
      cmp("R4 ss_active",     a_ss,    mss != 0);
      cmp("R2 phase",         a_ph,    mp);
      cmp("R8 fault_latched", a_lat,   ms == 4);
      cmp("R12 early ref_en",   b_ref,   sup);
      cmp("R12 early logic_en", b_logic, sup && ms != 4);
      cmp("R12 early boost_en", b_boost, on_at(3));
      cmp("R12 early pos_en",   b_pos,   on_at(6));
      cmp("R12 early phase",    b_ph,    mp);
      cmp("R12 early latched",  b_lat,   ms == 4);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; sup = 1'b1; rg = 1'b1; ot = 1'b0;
    uvb = 1'b0; uvl = 1'b0; uvn = 1'b0; uvp = 1'b0; pgl = 1'b1; dlb = 1'b1;
    #1 cmp_on = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 idle after reset
    cmp("R1 phase", a_ph, 0);
    cmp("R1 prot_drv_n", a_prot, 1);
    cmp("R1 boost_en", a_boost, 0);
    cmp("R1 fault_latched", a_lat, 0);
    cmp("R12 early ref_en in idle", b_ref, 1);
    cmp("R12 early logic_en in idle", b_logic, 1);

    // normal bring-up, with flags raised before they are armed (R7)
    uvb = 1'b1; pgl = 1'b0; dlb = 1'b0; en = 1'b1;
    tick(1);  cmp("R2 phase 1", a_ph, 1);
    tick(6);  cmp("R2 phase 2", a_ph, 2); cmp("R3 ref on", a_ref, 1); cmp("R3 prot off", a_prot, 1);
    tick(3);  uvb = 1'b0;
    tick(3);  cmp("R7 boost uv ignored", a_ph, 3); cmp("R3 boost on", a_boost, 1);
              cmp("R3 prot on", a_prot, 0); cmp("R4 ss active", a_ss, 1);
    tick(1);  uvn = 1'b1;
    tick(3);  cmp("R4 ss ended", a_ss, 0);
    tick(5);  uvn = 1'b0;
    tick(2);  cmp("R7 neg uv ignored", a_ph, 4); cmp("R3 neg on", a_neg, 1);
    tick(6);  cmp("R3 dly on", a_dly, 1); cmp("R7 gates ignored", a_ph, 5); pgl = 1'b1; dlb = 1'b1;
    tick(7);  cmp("R2 running", a_ph, 7); cmp("R3 pos on", a_pos, 1);
    tick(10); cmp("R2 still running", a_ph, 7);

    // R10 enable low while running and mid-sequence
    en = 1'b0;
    tick(1);  cmp("R10 idle", a_ph, 0); cmp("R10 boost off", a_boost, 0); cmp("R10 prot off", a_prot, 1);
    tick(3);  en = 1'b1;
    tick(10); en = 1'b0;
    tick(1);  cmp("R10 idle mid-seq", a_ph, 0);
    tick(2);

    // R5 reference not good -> timeout -> latch (R8), hold (R9)
    rg = 1'b0; en = 1'b1;
    tick(16); cmp("R5 phase held", a_ph, 2); cmp("R8 not yet latched", a_lat, 0);
              cmp("R8 ref held", a_ref, 1);
    tick(14); cmp("R8 latched", a_lat, 1); cmp("R8 ref off", a_ref, 0); cmp("R8 prot off", a_prot, 1);
              cmp("R12 ref kept", b_ref, 1); cmp("R12 logic off", b_logic, 0);
    rg = 1'b1;
    tick(20); cmp("R9 stays latched", a_lat, 1);
    en = 1'b0;
    tick(1);  cmp("R9 latch cleared", a_lat, 0);
    en = 1'b1;
    tick(1);  cmp("R9 restart", a_ph, 1);
    tick(36); cmp("R9 running again", a_ph, 7);

    // R6 over-temperature while running
    ot = 1'b1;
    tick(1);  cmp("R6 phase held", a_ph, 7);
    tick(5);  cmp("R8 outputs held", a_boost, 1); cmp("R6 not latched yet", a_lat, 0);
    ot = 1'b0;
    tick(10); cmp("R6 latched", a_lat, 1); cmp("R8 boost off", a_boost, 0);

    // R11 supply drop clears the latch and blocks start
    sup = 1'b0;
    tick(1);  cmp("R11 latch cleared", a_lat, 0); cmp("R11 idle", a_ph, 0);
              cmp("R12 ref follows supply", b_ref, 0); cmp("R12 logic follows supply", b_logic, 0);
    tick(5);  cmp("R11 no start", a_ph, 0);
    sup = 1'b1;
    tick(1);  cmp("R11 start after supply", a_ph, 1);
    tick(36); cmp("R11 running", a_ph, 7);

    // R7 positive rail undervoltage while running
    uvp = 1'b1;
    tick(1);  cmp("R7 pos uv fault", a_lat, 0); cmp("R7 phase held", a_ph, 7);
    tick(12); cmp("R7 pos uv latched", a_lat, 1);
    uvp = 1'b0; en = 1'b0;
    tick(2);

    // R7 delay-switch gate checked at end of phase 6
    en = 1'b1; dlb = 1'b0;
    tick(40); cmp("R7 gate fault holds phase 6", a_ph, 6); cmp("R7 gate not latched yet", a_lat, 0);
    tick(10); cmp("R7 gate latched", a_lat, 1);
    dlb = 1'b1; en = 1'b0;
    tick(3);  cmp("R10 final idle", a_ph, 0);

    summary();
    $finish;
  end

endmodule